// File: doc/BRIEF.md
# Per-Address Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using a table of small state entries indexed directly by the low bits of the branch's program counter. A fetch stage presents a PC on the lookup port and gets back a taken/not-taken guess combinationally. When the branch later resolves, the execute stage presents the same PC with the real outcome on the update port. The selected entry then moves to its next state on the following clock edge.

The kind of entry is fixed at elaboration. A single-bit entry simply remembers the last direction. A two-bit hysteresis state machine needs two agreeing outcomes to flip a strong guess. A wider saturating up/down counter has a configurable width. All three sit behind the same ports. A wrapping counter of correct guesses is provided for test. It counts updates whose outcome agreed with the guess the entry held just before that update.

Top module: `bimodal_predictor`

## Requirements
- R1: The entry index is the PC's low IDX_W bits; PCs that differ only above bit IDX_W-1 share one entry and get the same prediction.
- R2: With the last-outcome entry kind (entry width 1), the prediction equals the direction of the most recent update to that entry.
- R3: With the two-bit state-machine kind, states are encoded 0 to 3 and the prediction is taken exactly in states 2 and 3.
- R4: State-machine transitions on taken are 0→1, 1→2, 2→3 and 3→3. On not taken they are 3→2, 2→1, 1→0 and 0→0. From state 0, two taken outcomes are needed before the prediction turns taken, and from state 3, two not-taken outcomes are needed before it turns not taken.
- R5: With the saturating-counter kind (CNT_W bits), taken adds one and not taken subtracts one, holding at 0 and at 2^CNT_W-1 instead of wrapping.
- R6: With the saturating-counter kind, the prediction is taken exactly when the counter is at least 2^(CNT_W-1).
- R7: An update changes only the entry its PC selects; cycles without an update change no entry.
- R8: After reset every entry is zero (every lookup predicts not taken) and the hit count is zero.
- R9: Lookup is combinational; an update becomes visible after the next rising clock edge, so a lookup of the same entry in the update cycle returns the old prediction.
- R10: The hit count increases by one on each update whose outcome equals the entry's prediction before that update, and wraps modulo 2^ACC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookupPc | input | PC_W | PC of the branch being fetched |
| predTaken | output | 1 | Prediction for lookupPc, 1 = taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| hitCount | output | ACC_W | Wrapping count of correctly predicted updates |

## Verification
The bench drives the same biased pseudo-random update stream into one instance of each entry kind. It compares every prediction and the hit count against arithmetic models in the bench, and at intervals it sweeps all entries with updates idle. Strongly biased indexes drive the counter into both clamps. A design that wrapped instead of clamping would flip its prediction after a run of agreeing outcomes. The two-bit machine is pushed through alternating outcomes, where a one-step flip would show as mismatching predictions. Same-cycle lookups of the entry being updated catch a design that forwards the new value early. High-bit PC variations catch indexing on the wrong bits. The narrow hit counter is run past its wrap point, so a saturating or stuck counter is also caught.

// File: rtl/bimodal_pkg.sv
package bimodal_pkg;

  typedef enum logic [1:0] {
    ENTRY_LAST = 2'd0,
    ENTRY_FSM  = 2'd1,
    ENTRY_SAT  = 2'd2
  } entry_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic hitInc;
  } ctrl_strobe_t;

  function automatic int entryWidth(entry_kind_e kind, int cntW);
    case (kind)
      ENTRY_LAST: return 1;
      ENTRY_FSM:  return 2;
      default:    return cntW;
    endcase
  endfunction

endpackage

// File: rtl/bimodal_entry_next.sv
module bimodal_entry_next
  import bimodal_pkg::*;
#(
  parameter entry_kind_e KIND = ENTRY_FSM,
  parameter int          EW   = 2
) (
  input  logic [EW-1:0] cur,
  input  logic          taken,
  output logic [EW-1:0] nxt
);

  generate
    if (KIND == ENTRY_LAST) begin : g_last
      always_comb nxt = {EW{taken}};
    end else if (KIND == ENTRY_FSM) begin : g_fsm
      always_comb begin
        case (cur[1:0])
          2'b00:   nxt = taken ? 2'b01 : 2'b00;
          2'b01:   nxt = taken ? 2'b10 : 2'b00;
          2'b10:   nxt = taken ? 2'b11 : 2'b01;
          default: nxt = taken ? 2'b11 : 2'b10;
        endcase
      end
    end else begin : g_sat
      localparam logic [EW-1:0] TOP = {EW{1'b1}};
      always_comb begin
        nxt = cur;
        if (taken && cur != TOP)       nxt = cur + 1'b1;
        else if (!taken && cur != '0)  nxt = cur - 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/bimodal_ctrl.sv
module bimodal_ctrl
  import bimodal_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic [PC_W-1:0]  lookupPc,
  input  logic [PC_W-1:0]  updPc,
  input  logic             updValid,
  input  logic             updTaken,
  input  logic             wrPred,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] wrIdx,
  output ctrl_strobe_t     strobe
);

  logic unusedPcHigh;

  // Index is a plain truncation of the PC
  assign rdIdx = lookupPc[IDX_W-1:0];
  assign wrIdx = updPc[IDX_W-1:0];
  assign unusedPcHigh = ^{lookupPc[PC_W-1:IDX_W], updPc[PC_W-1:IDX_W]};

  always_comb begin
    strobe.wrEn   = updValid;
    strobe.hitInc = updValid && (wrPred == updTaken);
  end

endmodule

// File: rtl/bimodal_datapath.sv
module bimodal_datapath
  import bimodal_pkg::*;
#(
  parameter entry_kind_e KIND  = ENTRY_FSM,
  parameter int          IDX_W = 4,
  parameter int          EW    = 2,
  parameter int          ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrTaken,
  input  ctrl_strobe_t     strobe,
  output logic             rdPred,
  output logic             wrPred,
  output logic [ACC_W-1:0] hitCount
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][EW-1:0] tbl;
  logic [EW-1:0] wrCur;
  logic [EW-1:0] wrNext;

  assign wrCur  = tbl[wrIdx];
  // In every kind the top bit of the entry is the prediction
  assign rdPred = tbl[rdIdx][EW-1];
  assign wrPred = wrCur[EW-1];

  bimodal_entry_next #(.KIND(KIND), .EW(EW)) u_next (
    .cur  (wrCur),
    .taken(wrTaken),
    .nxt  (wrNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (strobe.wrEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrIdx == IDX_W'(i)) tbl[i] <= wrNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hitCount <= '0;
    else if (strobe.hitInc) hitCount <= hitCount + 1'b1;
  end

  // R7: idle cycles leave the table untouched
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrEn |=> $stable(tbl));

  // R10: no hit strobe, no count change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.hitInc |=> $stable(hitCount));

  generate
    if (KIND == ENTRY_LAST) begin : g_a_last
      a_r2_last_dir: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.wrEn |=> tbl[$past(wrIdx)][0] == $past(wrTaken));
    end else if (KIND == ENTRY_FSM) begin : g_a_fsm
      a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.wrEn && wrTaken && wrCur == 2'b00 |=> tbl[$past(wrIdx)] == 2'b01);
      a_r4_strong_hold: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.wrEn && !wrTaken && wrCur == 2'b11 |=> tbl[$past(wrIdx)] == 2'b10);
    end else begin : g_a_sat
      a_r5_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.wrEn && wrTaken && wrCur == {EW{1'b1}} |=> tbl[$past(wrIdx)] == {EW{1'b1}});
      a_r5_clamp_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.wrEn && !wrTaken && wrCur == '0 |=> tbl[$past(wrIdx)] == '0);
      a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.wrEn && wrTaken |=> tbl[$past(wrIdx)] >= $past(wrCur));
    end
  endgenerate

endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
  import bimodal_pkg::*;
#(
  parameter int          PC_W  = 16,
  parameter int          IDX_W = 4,
  parameter entry_kind_e KIND  = ENTRY_FSM,
  parameter int          CNT_W = 3,
  parameter int          ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lookupPc,
  output logic             predTaken,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic             updTaken,
  output logic [ACC_W-1:0] hitCount
);

  localparam int EW = entryWidth(KIND, CNT_W);

  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  logic             wrPred;
  ctrl_strobe_t     strobe;

  bimodal_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ctrl (
    .lookupPc(lookupPc),
    .updPc   (updPc),
    .updValid(updValid),
    .updTaken(updTaken),
    .wrPred  (wrPred),
    .rdIdx   (rdIdx),
    .wrIdx   (wrIdx),
    .strobe  (strobe)
  );

  bimodal_datapath #(.KIND(KIND), .IDX_W(IDX_W), .EW(EW), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdIdx   (rdIdx),
    .wrIdx   (wrIdx),
    .wrTaken (updTaken),
    .strobe  (strobe),
    .rdPred  (predTaken),
    .wrPred  (wrPred),
    .hitCount(hitCount)
  );

endmodule

// File: tb/bimodal_predictor_tb.sv
module bimodal_predictor_tb;
  import bimodal_pkg::*;

  localparam int PC_W  = 12;
  localparam int IDX_W = 3;
  localparam int CNT_W = 3;
  localparam int ACC_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SMAX  = (1 << CNT_W) - 1;
  localparam int SHALF = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic [PC_W-1:0] updPc = '0;
  logic updValid = 1'b0;
  logic updTaken = 1'b0;
  logic predLast, predFsm, predSat;
  logic [ACC_W-1:0] hitLast, hitFsm, hitSat;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int mLast [DEPTH];
  int mFsm  [DEPTH];
  int mSat  [DEPTH];
  int hLast = 0, hFsm = 0, hSat = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  bimodal_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .KIND(ENTRY_LAST), .CNT_W(CNT_W), .ACC_W(ACC_W))
    u_dut_last (.clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predLast),
                .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .hitCount(hitLast));
  bimodal_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .KIND(ENTRY_FSM), .CNT_W(CNT_W), .ACC_W(ACC_W))
    u_dut (.clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predFsm),
           .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .hitCount(hitFsm));
  bimodal_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .KIND(ENTRY_SAT), .CNT_W(CNT_W), .ACC_W(ACC_W))
    u_dut_sat (.clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predSat),
               .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .hitCount(hitSat));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pLast(int i); return mLast[i]; endfunction
  function automatic int pFsm(int i);  return (mFsm[i] >= 2) ? 1 : 0; endfunction
  function automatic int pSat(int i);  return (mSat[i] >= SHALF) ? 1 : 0; endfunction

  function automatic logic [15:0] nextLfsr(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // One cycle: drive at negedge, check combinational outputs, then apply model update
  task automatic step(input bit v, input logic [PC_W-1:0] upc, input bit tk,
                      input logic [PC_W-1:0] lpc);
    int li, ui;
    @(negedge clk);
    updValid = v; updPc = upc; updTaken = tk; lookupPc = lpc;
    #1;
    li = int'(lpc[IDX_W-1:0]);
    ui = int'(upc[IDX_W-1:0]);
    if (v && li == ui) begin
      chk("R9", "last same-cycle", int'(predLast), pLast(li));
      chk("R9", "fsm same-cycle",  int'(predFsm),  pFsm(li));
      chk("R9", "sat same-cycle",  int'(predSat),  pSat(li));
    end else begin
      chk("R2", "last lookup", int'(predLast), pLast(li));
      chk("R3", "fsm lookup",  int'(predFsm),  pFsm(li));
      chk("R6", "sat lookup",  int'(predSat),  pSat(li));
    end
    @(posedge clk);
    if (v) begin
      if (pLast(ui) == int'(tk)) hLast++;
      if (pFsm(ui)  == int'(tk)) hFsm++;
      if (pSat(ui)  == int'(tk)) hSat++;
      mLast[ui] = int'(tk);
      if (tk) begin
        if (mFsm[ui] < 3) mFsm[ui]++;
        if (mSat[ui] < SMAX) mSat[ui]++;
      end else begin
        if (mFsm[ui] > 0) mFsm[ui]--;
        if (mSat[ui] > 0) mSat[ui]--;
      end
    end
    #1;
    chk("R10", "last hits", int'(hitLast), hLast % (1 << ACC_W));
    chk("R10", "fsm hits",  int'(hitFsm),  hFsm  % (1 << ACC_W));
    chk("R10", "sat hits",  int'(hitSat),  hSat  % (1 << ACC_W));
  endtask

  task automatic sweep();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      updValid = 1'b0;
      lookupPc = PC_W'(i) | (PC_W'(i * 37) << IDX_W);
      #1;
      chk("R7", "last sweep", int'(predLast), pLast(i));
      chk("R4", "fsm sweep",  int'(predFsm),  pFsm(i));
      chk("R5", "sat sweep",  int'(predSat),  pSat(i));
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mLast[i] = 0; mFsm[i] = 0; mSat[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R8: reset contents
    for (int i = 0; i < DEPTH; i++) begin
      lookupPc = PC_W'(i);
      #1;
      chk("R8", "reset last", int'(predLast), 0);
      chk("R8", "reset fsm",  int'(predFsm),  0);
      chk("R8", "reset sat",  int'(predSat),  0);
    end
    chk("R8", "reset hits", int'(hitLast) + int'(hitFsm) + int'(hitSat), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: from state 0 the fsm needs two takens; R1: alias PC sees the entry
    step(1'b1, 12'h005, 1'b1, 12'h000);
    step(1'b0, 12'h000, 1'b0, 12'hF05);
    chk("R4", "fsm after one taken", int'(predFsm), 0);
    chk("R1", "alias last", int'(predLast), 1);
    step(1'b1, 12'h3A5, 1'b1, 12'h000);
    step(1'b0, 12'h000, 1'b0, 12'h805);
    chk("R4", "fsm after two taken", int'(predFsm), 1);
    chk("R1", "alias fsm", int'(predFsm), 1);

    // Clamp exercises on index 6
    for (int k = 0; k < 12; k++) step(1'b1, PC_W'(12'h046 + (k << IDX_W)), 1'b1, 12'h046);
    for (int k = 0; k < 12; k++) step(1'b1, 12'h0A6, 1'b0, 12'h0A6);
    // Alternating outcomes on index 2
    for (int k = 0; k < 10; k++) step(1'b1, 12'h1F2, k[0], 12'h1F2);
    sweep();

    // Biased pseudo-random stream
    for (int n = 0; n < 600; n++) begin
      logic [PC_W-1:0] upc, lpc;
      bit tk, v;
      int ix;
      lfsr = nextLfsr(lfsr); lfsr = nextLfsr(lfsr); lfsr = nextLfsr(lfsr);
      upc = lfsr[11:0];
      ix  = int'(upc[IDX_W-1:0]);
      if (ix < 2)      tk = (lfsr[15:13] != 3'd0);
      else if (ix < 4) tk = (lfsr[15:13] == 3'd0);
      else             tk = lfsr[15];
      v = (lfsr[12:11] != 2'd0);
      lpc = lfsr[14] ? upc : {lfsr[7:0], lfsr[15:12]};
      step(v, upc, tk, lpc);
      if (n % 50 == 49) sweep();
    end
    sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule